// File: doc/BRIEF.md
# Interrupt Destination Set Resolver

This block turns one interrupt message into the set of interrupt controllers that must receive it, in a system of `N_CTRL` controllers. It decodes the message's command word and destination byte against a table of per-controller identities. That table holds a physical ID, a logical-ID register, a format-model register and a present flag for each controller. It then drives one bit per controller in a registered target mask.

A controller can be reached in three ways. The first is by physical ID, or a physical broadcast. The second is by logical ID, under either a flat or a cluster model chosen per controller. The third is by a shorthand code in the command word, which overrides the destination byte. When the message asks for lowest-priority delivery, the mask is cut down to one controller. The result appears one clock after the message is presented. Injection into the controllers and the storage of their registers lie outside this block.

Top module: `irq_target_resolver`

## Requirements
- R1: In physical mode (command bit 11 = 0), with shorthand 0, a destination of 0xFF selects every present controller.
- R2: In physical mode, with shorthand 0, any other destination selects only the controller whose 8-bit physical ID equals the destination.
- R3: In logical mode (command bit 11 = 1), with shorthand 0, a controller is selected when the destination ANDed with its logical ID is nonzero. This applies when the controller's format model is 0xF (flat). The logical ID is bits [31:24] of its logical-ID register, and the format model is bits [31:28] of its format register.
- R4: In logical mode, a controller with format model 0x0 (cluster) is selected when two conditions both hold. The upper nibble of the destination must equal the upper nibble of its logical ID. The lower nibble of the destination ANDed with the lower nibble of its logical ID must also be nonzero.
- R5: In logical mode, a controller whose format model is neither 0x0 nor 0xF is never selected.
- R6: The shorthand field is command bits [19:18], and it overrides the destination byte. Code 0 uses the destination, and code 1 selects only the sender (`self_idx_i`). Code 2 selects all controllers, and code 3 selects all controllers except the sender.
- R7: When the delivery mode in command bits [10:8] equals 1 (lowest priority), only the lowest-index controller of the resolved mask is kept. If the mask is empty, the result is empty. Any other delivery mode passes the resolved mask unchanged.
- R8: A controller whose present flag is 0 never appears in the output mask, under any addressing mode or shorthand.
- R9: `mask_o` and `valid_o` are registered. A message presented with `valid_i` high at a rising edge appears after that edge, and back-to-back messages resolve one per cycle. In a cycle after `valid_i` was low, `valid_o` is 0 and `mask_o` is all zeros.
- R10: The asynchronous active-low reset `rst_ni` forces `valid_o` to 0 and `mask_o` to all zeros at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | A message is presented this cycle |
| cmd_i | input | 32 | Command word: shorthand [19:18], logical mode [11], delivery mode [10:8] |
| dest_i | input | 8 | Destination byte |
| self_idx_i | input | $clog2(N_CTRL) | Index of the sending controller |
| present_i | input | N_CTRL | Present flag per controller |
| phys_id_i | input | N_CTRL*8 | Physical ID per controller, controller i in bits [8i+7:8i] |
| logid_reg_i | input | N_CTRL*32 | Logical-ID register per controller, ID in bits [31:24] of each word |
| fmt_reg_i | input | N_CTRL*32 | Format register per controller, model in bits [31:28] of each word |
| valid_o | output | 1 | Registered copy of valid_i |
| mask_o | output | N_CTRL | Resolved target mask, bit i = controller i |

## Verification
In one message the shorthand override and the lowest-priority reduction can apply together. The presence filter can also combine with the self-only shorthand. The bench provokes these cases with vectors that exclude the sender and request lowest priority at once. It also uses a vector that names an absent sender.

Each such case is judged against a hand-derived mask. That mask shows the reduction acting after both the shorthand and the presence filter. For example, excluding sender 0 under lowest priority must leave only controller 1. A sender that is absent must yield an empty mask.

// File: rtl/itr_pkg.sv
package itr_pkg;
  localparam int unsigned CMD_W  = 32;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned SH_LSB = 18;
  localparam int unsigned LOG_BIT = 11;
  localparam int unsigned DLV_LSB = 8;

  typedef enum logic [1:0] {
    SH_DEST     = 2'd0,
    SH_SELF     = 2'd1,
    SH_ALL      = 2'd2,
    SH_OTHERS   = 2'd3
  } shorthand_e;

  localparam logic [2:0] DLV_LOWEST = 3'd1;
  localparam logic [3:0] FMT_FLAT    = 4'hF;
  localparam logic [3:0] FMT_CLUSTER = 4'h0;
endpackage

// File: rtl/itr_match.sv
module itr_match
  import itr_pkg::*;
#(
  parameter int unsigned N_CTRL = 8,
  parameter int unsigned ID_W   = 8
) (
  input  logic [ID_W-1:0]         dest_i,
  input  logic                    logical_i,
  input  logic [N_CTRL*ID_W-1:0]  phys_id_i,
  input  logic [N_CTRL*REG_W-1:0] logid_reg_i,
  input  logic [N_CTRL*REG_W-1:0] fmt_reg_i,
  output logic [N_CTRL-1:0]       hit_o
);
  localparam int unsigned HALF = ID_W / 2;
  localparam logic [ID_W-1:0] BCAST = '1;

  logic bcast;
  assign bcast = (dest_i == BCAST);

  for (genvar g = 0; g < N_CTRL; g++) begin : g_ctrl
    logic [ID_W-1:0] pid, lid;
    logic [3:0]      fmt;
    logic            phys_hit, flat_hit, clus_hit;
    logic            unused_bits;

    assign pid = phys_id_i[g*ID_W +: ID_W];
    assign lid = logid_reg_i[g*REG_W + REG_W - ID_W +: ID_W];
    assign fmt = fmt_reg_i[g*REG_W + REG_W - 4 +: 4];
    assign unused_bits = ^{logid_reg_i[g*REG_W +: REG_W-ID_W],
                           fmt_reg_i[g*REG_W +: REG_W-4]};

    assign phys_hit = bcast || (pid == dest_i);
    assign flat_hit = (fmt == FMT_FLAT) && |(dest_i & lid);
    assign clus_hit = (fmt == FMT_CLUSTER) &&
                      (dest_i[ID_W-1:HALF] == lid[ID_W-1:HALF]) &&
                      |(dest_i[HALF-1:0] & lid[HALF-1:0]);

    assign hit_o[g] = logical_i ? (flat_hit || clus_hit) : phys_hit;

    // r5_: unsupported format model never matches in logical mode
    always_comb begin
      if (logical_i && fmt != FMT_FLAT && fmt != FMT_CLUSTER)
        p_bad_fmt_r5: assert (hit_o[g] == 1'b0 || $isunknown(fmt));
    end
  end
endmodule

// File: rtl/itr_shorthand.sv
module itr_shorthand
  import itr_pkg::*;
#(
  parameter int unsigned N_CTRL = 8,
  localparam int unsigned SELF_W = (N_CTRL > 1) ? $clog2(N_CTRL) : 1
) (
  input  logic [1:0]        sh_i,
  input  logic [N_CTRL-1:0] hit_i,
  input  logic [SELF_W-1:0] self_idx_i,
  input  logic [N_CTRL-1:0] present_i,
  output logic [N_CTRL-1:0] mask_o
);
  logic [N_CTRL-1:0] self_oh, raw;

  assign self_oh = N_CTRL'(1) << self_idx_i;

  always_comb begin
    unique case (shorthand_e'(sh_i))
      SH_DEST:   raw = hit_i;
      SH_SELF:   raw = self_oh;
      SH_ALL:    raw = '1;
      SH_OTHERS: raw = ~self_oh;
      default:   raw = '0;
    endcase
  end

  assign mask_o = raw & present_i;
endmodule

// File: rtl/itr_lowest_pick.sv
module itr_lowest_pick #(
  parameter int unsigned N_CTRL = 8
) (
  input  logic              en_i,
  input  logic [N_CTRL-1:0] mask_i,
  output logic [N_CTRL-1:0] mask_o
);
  logic [N_CTRL:0]   seen;
  logic [N_CTRL-1:0] first;

  assign seen[0] = 1'b0;
  for (genvar g = 0; g < N_CTRL; g++) begin : g_chain
    assign first[g]  = mask_i[g] & ~seen[g];
    assign seen[g+1] = seen[g] | mask_i[g];
  end

  assign mask_o = en_i ? first : mask_i;

  // r7_: reduced mask is a subset of the input and at most one-hot
  always_comb begin
    if (en_i) begin
      p_pick_onehot_r7: assert ($onehot0(mask_o) || $isunknown(mask_i));
      p_pick_subset_r7: assert (((mask_o & ~mask_i) == '0) || $isunknown(mask_i));
    end
  end
endmodule

// File: rtl/irq_target_resolver.sv
module irq_target_resolver
  import itr_pkg::*;
#(
  parameter int unsigned N_CTRL = 8,
  parameter int unsigned ID_W   = 8,
  localparam int unsigned SELF_W = (N_CTRL > 1) ? $clog2(N_CTRL) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [CMD_W-1:0]        cmd_i,
  input  logic [ID_W-1:0]         dest_i,
  input  logic [SELF_W-1:0]       self_idx_i,
  input  logic [N_CTRL-1:0]       present_i,
  input  logic [N_CTRL*ID_W-1:0]  phys_id_i,
  input  logic [N_CTRL*REG_W-1:0] logid_reg_i,
  input  logic [N_CTRL*REG_W-1:0] fmt_reg_i,
  output logic                    valid_o,
  output logic [N_CTRL-1:0]       mask_o
);
  logic [1:0]        sh;
  logic              logical;
  logic [2:0]        dlv;
  logic              lowest;
  logic [N_CTRL-1:0] hit, sel, picked;
  logic              unused_cmd;

  assign sh      = cmd_i[SH_LSB +: 2];
  assign logical = cmd_i[LOG_BIT];
  assign dlv     = cmd_i[DLV_LSB +: 3];
  assign lowest  = (dlv == DLV_LOWEST);
  assign unused_cmd = ^{cmd_i[CMD_W-1:SH_LSB+2], cmd_i[SH_LSB-1:LOG_BIT+1],
                        cmd_i[DLV_LSB-1:0]};

  itr_match #(.N_CTRL(N_CTRL), .ID_W(ID_W)) u_match (
    .dest_i      (dest_i),
    .logical_i   (logical),
    .phys_id_i   (phys_id_i),
    .logid_reg_i (logid_reg_i),
    .fmt_reg_i   (fmt_reg_i),
    .hit_o       (hit)
  );

  itr_shorthand #(.N_CTRL(N_CTRL)) u_sh (
    .sh_i       (sh),
    .hit_i      (hit),
    .self_idx_i (self_idx_i),
    .present_i  (present_i),
    .mask_o     (sel)
  );

  itr_lowest_pick #(.N_CTRL(N_CTRL)) u_pick (
    .en_i   (lowest),
    .mask_i (sel),
    .mask_o (picked)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      mask_o  <= '0;
    end else begin
      valid_o <= valid_i;
      mask_o  <= valid_i ? picked : '0;
    end
  end

  logic [N_CTRL-1:0] self_bit;
  assign self_bit = N_CTRL'(1) << self_idx_i;

  p_valid_follow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_idle_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (mask_o == '0));
  p_present_only_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> ((mask_o & ~$past(present_i)) == '0));
  p_self_only_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sh == 2'd1) |=> ((mask_o & ~$past(self_bit)) == '0));
  p_not_self_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sh == 2'd3) |=> ((mask_o & $past(self_bit)) == '0));
  p_lowest_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && lowest) |=> $onehot0(mask_o));
endmodule

// File: tb/tb_irq_target_resolver.sv
module tb_irq_target_resolver;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned N = 8;
  localparam int unsigned NV = 19;

  // entry: [31:30] shorthand, [29] logical, [28:26] delivery, [23:16] dest,
  //        [15:8] sender, [7:0] expected mask
  localparam logic [31:0] VEC [NV] = '{
    32'h00_FF_02_BF, 32'h00_13_02_08, 32'h00_16_02_00, 32'h00_55_02_00,
    32'h20_05_02_05, 32'h20_23_02_33, 32'h20_24_02_04, 32'h24_23_02_01,
    32'h40_00_02_04, 32'h80_13_02_BF, 32'hC0_00_02_BB, 32'hC0_00_06_BF,
    32'hC4_00_00_02, 32'h04_FF_02_01, 32'h40_00_06_00, 32'h20_00_02_00,
    32'h20_80_02_00, 32'h30_23_02_33, 32'h04_55_02_00
  };

  function automatic string vec_req(int i);
    case (i)
      0: return "R1";   1: return "R2";   2: return "R8";   3: return "R2";
      4: return "R3";   5: return "R4";   6: return "R8";   7: return "R7";
      8: return "R6";   9: return "R6";  10: return "R6";  11: return "R6";
      12: return "R7"; 13: return "R7";  14: return "R8";  15: return "R3";
      16: return "R5"; 17: return "R7";  default: return "R7";
    endcase
  endfunction

  logic clk = 1'b0, rst_ni = 1'b0, valid_i = 1'b0;
  logic [31:0]    cmd_i = '0;
  logic [7:0]     dest_i = '0;
  logic [2:0]     self_idx_i = '0;
  logic [N-1:0]   present_i = 8'hBF;
  logic [N*8-1:0] phys_id_i;
  logic [N*32-1:0] logid_reg_i, fmt_reg_i;
  logic           valid_o;
  logic [N-1:0]   mask_o;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_target_resolver #(.N_CTRL(N), .ID_W(8)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .cmd_i(cmd_i),
    .dest_i(dest_i), .self_idx_i(self_idx_i), .present_i(present_i),
    .phys_id_i(phys_id_i), .logid_reg_i(logid_reg_i), .fmt_reg_i(fmt_reg_i),
    .valid_o(valid_o), .mask_o(mask_o)
  );

  initial begin
    logic [7:0] lid [N] = '{8'h01, 8'h02, 8'h04, 8'h08, 8'h21, 8'h22, 8'h24, 8'hFF};
    logic [3:0] fmt [N] = '{4'hF, 4'hF, 4'hF, 4'hF, 4'h0, 4'h0, 4'hF, 4'h5};
    for (int i = 0; i < N; i++) begin
      phys_id_i[i*8 +: 8]     = 8'h10 + 8'(i);
      logid_reg_i[i*32 +: 32] = {lid[i], 24'h5A5A5A};
      fmt_reg_i[i*32 +: 32]   = {fmt[i], 28'hFFFFFFF};
    end
  end

  task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp, logic vact, logic vexp);
    checks++;
    if (act !== exp || vact !== vexp) begin
      errors++;
      $display("FAIL %s: mask=%h valid=%b expected mask=%h valid=%b", req, act, vact, exp, vexp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic drive(logic [31:0] v);
    cmd_i      = {12'h0, v[31:30], 6'h0, v[29], v[28:26], 8'h0};
    dest_i     = v[23:16];
    self_idx_i = v[10:8];
    valid_i    = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD*10000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    #(CLK_PERIOD/4);
    check("R10", mask_o, '0, valid_o, 1'b0);  // reset state
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R9", mask_o, '0, valid_o, 1'b0);   // idle after reset

    // back-to-back vector walk, one message per cycle
    drive(VEC[0]);
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      check(vec_req(i), mask_o, VEC[i][7:0], valid_o, 1'b1);
      if (i + 1 < NV) drive(VEC[i+1]);
      else valid_i = 1'b0;
    end
    @(negedge clk);
    check("R9", mask_o, '0, valid_o, 1'b0);   // valid dropped clears mask

    // shorthand ignores destination byte and mode: self-only with logical dest
    drive(32'h60_FF_05_00);
    @(negedge clk);
    check("R6", mask_o, 8'h20, valid_o, 1'b1);

    // presence filter with a changed table: clear controller 0, broadcast lowest
    present_i = 8'hBE;
    drive(32'h04_FF_02_00);
    @(negedge clk);
    check("R8", mask_o, 8'h02, valid_o, 1'b1);
    present_i = 8'hBF;

    // message held but valid low: output stays empty
    valid_i = 1'b0;
    cmd_i = 32'h0008_0000;
    @(negedge clk);
    check("R9", mask_o, '0, valid_o, 1'b0);

    // asynchronous reset mid-stream
    drive(VEC[0]);
    @(negedge clk);
    check("R1", mask_o, 8'hBF, valid_o, 1'b1);
    #(CLK_PERIOD/4);
    rst_ni = 1'b0;
    #1;
    check("R10", mask_o, '0, valid_o, 1'b0);
    valid_i = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R10", mask_o, '0, valid_o, 1'b0);

    finish_run();
  end
endmodule